// File: doc/BRIEF.md
# Period Timer with Edge Capture

This block is a 16-bit up-counter that runs from a selectable clock-enable tick. It wraps to zero when the count reaches a programmable period. Each wrap sets a period interrupt flag. At the same time, a chosen edge on an external input copies the running count into a capture register and sets a separate capture flag.

Software reads the captured count together with the number of period interrupts it has seen. This lets it measure pulses that are longer than one counter period. The tick source is either a power-of-two division of the system clock or a match pulse from a neighbouring timer.

The block is programmed through a small word-wide register bus:

| Address | Register | Access |
|---------|----------|--------|
| 0 | control | read/write |
| 1 | period | read/write |
| 2 | capture | read only |
| 3 | live count | read only |

Each interrupt flag has its own acknowledge input.

Top module: `capture_timer`

## Requirements
- R1: The counter moves only on a tick while the run condition holds, i.e. control bit 0 (enable) is 1 and control bits [2:1] (mode) equal 01. With enable at 0 or any other mode value, the count holds its value.
- R2: Control bits [5:3] select the tick source as follows:
  - 0 to 6 give one tick every 1, 2, 4, 8, 32, 128 or 512 clock cycles. The first tick comes that many cycles after the run condition starts.
  - 7 uses each cycle in which `ext_tick` is high.
  - The divider restarts from zero whenever the run condition is false.
- R3: On a tick in which the count equals the active period, the count returns to 0 and `match_irq` becomes 1 on the same clock edge.
- R4: A control write with bit 8 set clears the count on that edge, ahead of any tick. Bit 8 is not stored and reads back as 0.
- R5: On a capture edge, the capture register takes the count held before that clock edge and `cap_irq` becomes 1. When this coincides with a wrap, the register gets the pre-wrap value.
- R6: Control bits [7:6] select the capture edge: 00 none, 01 falling, 10 rising, 11 both. `cap_pin` passes two synchronizer flops and a history flop. A change made before clock edge k is therefore captured at edge k+2.
- R7: Writes to the period register go to a holding register. While running, the active period loads from it only on a wrap. While not running, the active period follows the holding register.
- R8: `match_ack` clears `match_irq` and `cap_ack` clears `cap_irq`. A flag set in the same cycle as its acknowledge stays set. Both flags are 0 after reset.
- R9: `bus_rdata` is combinational and shows the following registers, zero-extended where narrower than the bus:
  - address 0: control bits [7:0]
  - address 1: the period holding register
  - address 2: the capture register
  - address 3: the live count

  Every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| ext_tick | input | 1 | Match pulse from another timer, used as tick source 7 |
| cap_pin | input | 1 | Asynchronous capture input |
| match_ack | input | 1 | Clears the period interrupt flag |
| cap_ack | input | 1 | Clears the capture interrupt flag |
| match_irq | output | 1 | Period interrupt flag |
| cap_irq | output | 1 | Capture interrupt flag |

## Verification
The in-line properties check the following on every cycle:
- a wrap leaves a zero count and a raised period flag;
- the active period reloads from the holding register on a wrap;
- a capture stores the previous cycle's count;
- acknowledges lose to simultaneous sets;
- the count holds in any cycle with neither a tick nor a software clear;
- the divider sits at zero after a cycle without the run condition.

The bench scenarios cover the behaviour that spans many cycles or depends on the register map:
- the exact tick spacing of each divider tap and the divider restart;
- the external tick source;
- the three-edge latency of the capture path;
- the four polarity encodings;
- a capture landing on the very cycle of a wrap.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'b00,
        MODE_CAPTURE = 2'b01,
        MODE_RSVD2   = 2'b10,
        MODE_RSVD3   = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_pol_e;

    // bit 8 clear strobe, [7:6] polarity, [5:3] tick select, [2:1] mode, [0] enable
    typedef struct packed {
        logic      clr;
        edge_pol_e pol;
        logic [2:0] tick_sel;
        tmr_mode_e mode;
        logic      en;
    } ctrl_t;

    localparam int CTRL_W = 9;
    localparam int NUM_TAPS = 7;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_CAPT   = 2'd2;
    localparam logic [1:0] ADDR_COUNT  = 2'd3;

    // log2 of the division for each internal tap
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 3;
            4:       return 5;
            5:       return 7;
            default: return 9;
        endcase
    endfunction

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler
    import ct_pkg::*;
#(
    parameter int PRE_W = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] tick_sel,
    input  logic       ext_tick,
    output logic       tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [7:0] src;

    always_comb begin
        s_d = s_q;
        if (run) s_d.pre = s_q.pre + 1'b1;
        else     s_d.pre = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int SH = tap_shift(i);
        if (SH == 0) begin : g_full
            assign src[i] = 1'b1;
        end else begin : g_div
            assign src[i] = &s_q.pre[SH-1:0];
        end
    end
    assign src[7] = ext_tick;

    assign tick = run & src[tick_sel];

    assert_pre_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.pre == '0));

endmodule

// File: rtl/ct_edge_sync.sv
module ct_edge_sync
    import ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_pol_e pol,
    output logic      hit
);

    typedef struct packed {
        logic [SYNC_STAGES:0] chain;
    } sync_state_t;

    sync_state_t s_d, s_q;
    logic lvl, prev;

    always_comb begin
        s_d = s_q;
        s_d.chain = {s_q.chain[SYNC_STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl  = s_q.chain[SYNC_STAGES-1];
    assign prev = s_q.chain[SYNC_STAGES];

    always_comb begin
        case (pol)
            EDGE_FALL: hit = prev & ~lvl;
            EDGE_RISE: hit = lvl & ~prev;
            EDGE_BOTH: hit = lvl ^ prev;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/ct_core.sv
module ct_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             sw_clr,
    input  logic [CNT_W-1:0] period_buf,
    input  logic             cap_hit,
    input  logic             match_ack,
    input  logic             cap_ack,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             match_flag,
    output logic             cap_flag
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] cap;
        logic             mflag;
        logic             cflag;
    } core_state_t;

    core_state_t s_d, s_q;
    logic match;

    assign match = tick && (s_q.cnt == s_q.active);

    always_comb begin
        s_d = s_q;

        if (sw_clr)     s_d.cnt = '0;
        else if (match) s_d.cnt = '0;
        else if (tick)  s_d.cnt = s_q.cnt + 1'b1;

        if (!run || match) s_d.active = period_buf;

        if (cap_hit) s_d.cap = s_q.cnt;

        if (match)          s_d.mflag = 1'b1;
        else if (match_ack) s_d.mflag = 1'b0;

        if (cap_hit)      s_d.cflag = 1'b1;
        else if (cap_ack) s_d.cflag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count      = s_q.cnt;
    assign capture    = s_q.cap;
    assign match_flag = s_q.mflag;
    assign cap_flag   = s_q.cflag;

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sw_clr) |=> $stable(s_q.cnt));
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (s_q.cnt == '0));
    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> s_q.mflag);
    assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (s_q.cnt == '0));
    assert_capt_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (s_q.cap == $past(s_q.cnt)) && s_q.cflag);
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && match) |=> (s_q.active == $past(period_buf)));
    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ack && !match) |=> !s_q.mflag);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ack && cap_hit) |=> s_q.cflag);

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import ct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_tick,
    input  logic             cap_pin,
    input  logic             match_ack,
    input  logic             cap_ack,
    output logic             match_irq,
    output logic             cap_irq
);

    localparam int RD_PAD = CNT_W - (CTRL_W - 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] pbuf;
    } reg_state_t;

    reg_state_t s_d, s_q;
    ctrl_t      wr_ctrl;
    logic       sw_clr, run, tick, cap_hit;
    logic [CNT_W-1:0] count, capture;

    assign wr_ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);

    always_comb begin
        s_d    = s_q;
        sw_clr = 1'b0;
        if (bus_wr && bus_addr == ADDR_CTRL) begin
            s_d.ctrl     = wr_ctrl;
            s_d.ctrl.clr = 1'b0;
            sw_clr       = wr_ctrl.clr;
        end
        if (bus_wr && bus_addr == ADDR_PERIOD) s_d.pbuf = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run = s_q.ctrl.en && (s_q.ctrl.mode == MODE_CAPTURE);

    ct_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick_sel (s_q.ctrl.tick_sel),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    ct_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_pin),
        .pol   (s_q.ctrl.pol),
        .hit   (cap_hit)
    );

    ct_core #(.CNT_W(CNT_W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .sw_clr     (sw_clr),
        .period_buf (s_q.pbuf),
        .cap_hit    (cap_hit),
        .match_ack  (match_ack),
        .cap_ack    (cap_ack),
        .count      (count),
        .capture    (capture),
        .match_flag (match_irq),
        .cap_flag   (cap_irq)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:   bus_rdata = {{RD_PAD{1'b0}}, s_q.ctrl[CTRL_W-2:0]};
            ADDR_PERIOD: bus_rdata = s_q.pbuf;
            ADDR_CAPT:   bus_rdata = capture;
            default:     bus_rdata = count;
        endcase
    end

    assert_clr_unstored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ctrl.clr);

endmodule

// File: tb/test_capture_timer.sv
module test_capture_timer;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         ext_tick = 1'b0;
    logic         cap_pin = 1'b0;
    logic         match_ack = 1'b0;
    logic         cap_ack = 1'b0;
    logic         match_irq, cap_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // polarity, new pin level, expected capture flag
    localparam logic [3:0] VEC [8] = '{
        {2'b00, 1'b0, 1'b0}, {2'b00, 1'b1, 1'b0},
        {2'b01, 1'b0, 1'b1}, {2'b01, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b0}, {2'b10, 1'b1, 1'b1},
        {2'b11, 1'b0, 1'b1}, {2'b11, 1'b1, 1'b1}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    capture_timer i_capture_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
        .cap_pin(cap_pin), .match_ack(match_ack), .cap_ack(cap_ack),
        .match_irq(match_irq), .cap_irq(cap_irq)
    );

    function automatic logic [W-1:0] cw(input logic clr, input logic [1:0] pol,
                                        input logic [2:0] sel, input logic [1:0] mode,
                                        input logic en);
        return {{(W-9){1'b0}}, clr, pol, sel, mode, en};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_mack();
        @(negedge clk); match_ack = 1'b1;
        @(posedge clk); #1; match_ack = 1'b0;
    endtask

    task automatic pulse_cack();
        @(negedge clk); cap_ack = 1'b1;
        @(posedge clk); #1; cap_ack = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
        end
    end

    initial begin
        logic [W-1:0] v, held;
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // reset state (R9, R8)
        rd(2'd0, v); chk(v == 0, "R9 ctrl reset", v, 0);
        rd(2'd3, v); chk(v == 0, "R9 count reset", v, 0);
        chk(!match_irq && !cap_irq, "R8 flags reset", {match_irq, cap_irq}, 0);

        // R1: wrong mode holds the count
        wr(2'd1, 16'hFFFF);
        wr(2'd0, cw(0, 2'b00, 3'd0, 2'b00, 1));
        edges(5);
        rd(2'd3, v); chk(v == 0, "R1 mode 00 holds", v, 0);
        rd(2'd0, v); chk(v == 16'h0001, "R9 ctrl readback", v, 1);

        // R2: divide by 1
        wr(2'd0, cw(1, 2'b00, 3'd0, 2'b01, 1));
        edges(6);
        rd(2'd3, v); chk(v == 6, "R2 fx/1 count", v, 6);

        // R2: divide by 8, then restart of divider
        wr(2'd0, cw(0, 2'b00, 3'd3, 2'b01, 0));
        wr(2'd0, cw(1, 2'b00, 3'd3, 2'b01, 1));
        edges(80);
        rd(2'd3, v); chk(v == 10, "R2 fx/8 count", v, 10);
        edges(3);
        wr(2'd0, cw(0, 2'b00, 3'd3, 2'b01, 0));
        wr(2'd0, cw(0, 2'b00, 3'd3, 2'b01, 1));
        edges(7);
        rd(2'd3, v); chk(v == 10, "R2 divider restart early", v, 10);
        edges(1);
        rd(2'd3, v); chk(v == 11, "R2 divider restart tick", v, 11);

        // R2: external tick source
        wr(2'd0, cw(1, 2'b00, 3'd7, 2'b01, 1));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
        end
        edges(5);
        rd(2'd3, v); chk(v == 3, "R2 external ticks", v, 3);

        // R3 / R7: wrap at period 4, reload to 9 on the wrap
        wr(2'd0, cw(0, 2'b00, 3'd0, 2'b01, 0));
        wr(2'd1, 16'd4);
        wr(2'd0, cw(1, 2'b00, 3'd0, 2'b01, 1));
        wr(2'd1, 16'd9);
        edges(3);
        rd(2'd3, v); chk(v == 4, "R3 count at period", v, 4);
        chk(!match_irq, "R3 no flag before wrap", match_irq, 0);
        edges(1);
        rd(2'd3, v); chk(v == 0, "R3 wrap to zero", v, 0);
        chk(match_irq, "R3 flag on wrap", match_irq, 1);
        edges(9);
        rd(2'd3, v); chk(v == 9, "R7 new period reached", v, 9);
        edges(1);
        rd(2'd3, v); chk(v == 0, "R7 wrap at new period", v, 0);
        rd(2'd1, v); chk(v == 9, "R9 period readback", v, 9);

        // R8: acknowledge, then set beats acknowledge
        pulse_mack();
        chk(!match_irq, "R8 ack clears", match_irq, 0);
        wr(2'd0, cw(0, 2'b00, 3'd0, 2'b01, 0));
        wr(2'd1, 16'd0);
        wr(2'd0, cw(1, 2'b00, 3'd0, 2'b01, 1));
        edges(2);
        pulse_mack();
        chk(match_irq, "R8 set wins over ack", match_irq, 1);
        wr(2'd0, cw(0, 2'b00, 3'd0, 2'b01, 0));
        pulse_mack();
        chk(!match_irq, "R8 ack after stop", match_irq, 0);

        // R4: software clear while running
        wr(2'd1, 16'hFFFF);
        wr(2'd0, cw(1, 2'b00, 3'd0, 2'b01, 1));
        edges(5);
        rd(2'd3, v); chk(v == 5, "R4 running before clear", v, 5);
        wr(2'd0, cw(1, 2'b00, 3'd0, 2'b01, 1));
        rd(2'd3, v); chk(v == 0, "R4 clear wins", v, 0);
        edges(2);
        rd(2'd3, v); chk(v == 2, "R4 counts after clear", v, 2);

        // R5 / R6: capture coinciding with wrap at period 6
        wr(2'd0, cw(0, 2'b10, 3'd0, 2'b01, 0));
        wr(2'd1, 16'd6);
        pulse_mack();
        pulse_cack();
        wr(2'd0, cw(1, 2'b10, 3'd0, 2'b01, 1));
        edges(4);
        cap_pin = 1'b1;
        edges(2);
        chk(!cap_irq, "R6 latency not yet", cap_irq, 0);
        edges(1);
        chk(cap_irq, "R6 latency flag", cap_irq, 1);
        rd(2'd2, v); chk(v == 6, "R5 pre-wrap capture", v, 6);
        chk(match_irq, "R5 wrap same cycle", match_irq, 1);
        rd(2'd3, v); chk(v == 0, "R5 count wrapped", v, 0);

        // R5: capture of a stopped count
        wr(2'd0, cw(0, 2'b10, 3'd0, 2'b01, 0));
        rd(2'd3, held);
        pulse_cack();
        cap_pin = 1'b0; edges(4);
        chk(!cap_irq, "R6 falling ignored in rise mode", cap_irq, 0);
        cap_pin = 1'b1; edges(4);
        rd(2'd2, v); chk(v == held, "R5 captured held count", v, held);
        chk(cap_irq, "R5 capture flag", cap_irq, 1);

        // R6: polarity table
        foreach (VEC[i]) begin
            pulse_cack();
            wr(2'd0, cw(0, VEC[i][3:2], 3'd0, 2'b01, 0));
            cap_pin = VEC[i][1];
            edges(4);
            chk(cap_irq == VEC[i][0], "R6 polarity row", cap_irq, VEC[i][0]);
        end

        done = 1'b1;
        report();
    end

endmodule